// File: doc/BRIEF.md
# Control-register access legality guard

This block sits beside the decode stage of a RISC-V core and judges each control-register instruction before it runs. It receives the 32-bit instruction word, the current privilege encoding and the trap-virtual-memory bit of the machine status register. One cycle later it reports whether the access is allowed. If it is not allowed, it raises an illegal-instruction exception with its cause code and trap value.

The check works as follows. First the block recognises the SYSTEM opcode and the six control-register variants. It then works out whether the instruction writes the register. Next it looks the address up in a table of address spans defined for each mode. It applies the read-only and minimum-privilege fields held in the address itself. Last, it traps Supervisor-mode access to the address-translation register while virtual-memory trapping is enabled. Any other instruction passes through with no exception. The register file, the read-data path and the trap entry logic live elsewhere.

Top module: `csr_access_guard`

## Requirements
- R1: A result appears on the outputs exactly one clock after a cycle with `in_valid` high, with `out_valid` high. `out_valid` is low in the cycle after a cycle with `in_valid` low.
- R2: An instruction whose bits [6:0] are not 1110011, or whose funct3 (bits [14:12]) is 000 or 100, is reported with `legal` high and `exc_valid` low.
- R3: funct3 001 and 101 (register and immediate swap) always count as writes. funct3 010, 011, 110 and 111 (set and clear forms) count as writes only when bits [19:15] are nonzero.
- R4: An access that counts as a write to an address whose bits [11:10] are 11 is illegal. A non-writing access to such an address is subject only to the other checks.
- R5: An access is illegal when the privilege encoding (User 00, Supervisor 01, Machine 11), taken as an unsigned number, is below address bits [9:8].
- R6: Addresses 0x300–0x306, 0x340–0x344 and 0xF11–0xF14 are defined only when the privilege is Machine.
- R7: Addresses 0x100, 0x102–0x106, 0x140–0x144 and 0x180 are defined in Supervisor and Machine. Every other address is undefined, and access to it is illegal.
- R8: Access to address 0x180 in Supervisor mode while `tvm` is 1 is illegal. With `tvm` at 0, or in Machine mode, it is legal.
- R9: Privilege encoding 10 is reserved, and every control-register access made with it is illegal.
- R10: An illegal access gives `exc_valid` high, `legal` low, `exc_cause` equal to 2 and `exc_tval` equal to the zero-extended instruction word. Otherwise `exc_cause` and `exc_tval` are zero.
- R11: A synchronous, active-high `rst` clears `out_valid`, `legal`, `exc_valid`, `exc_cause` and `exc_tval` at the next clock edge, whatever the other inputs are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Instruction presented this cycle |
| instr | input | 32 | Instruction word |
| priv | input | 2 | Current privilege encoding |
| tvm | input | 1 | Trap-virtual-memory bit of the machine status register |
| out_valid | output | 1 | Result for the instruction of the previous cycle |
| legal | output | 1 | Instruction may proceed |
| exc_valid | output | 1 | Illegal-instruction exception raised |
| exc_cause | output | CAUSE_W | Exception cause code |
| exc_tval | output | XLEN | Exception trap value |

## Verification
Every output of this block is due exactly one rising edge after the cycle in which its instruction was presented. There is no other latency, and nothing is carried from one instruction to the next. The bench presents each instruction at a falling edge and queues its expected result at that moment. It compares all five outputs a quarter period after the following rising edge. A result that shows up with no queued expectation counts as a failure, as does a queued expectation that finds `out_valid` low. Reset vectors queue all-zero expectations on the same one-edge schedule.

// File: rtl/csr_guard_pkg.sv
package csr_guard_pkg;

   typedef enum logic [1:0] {
      PRIV_USER  = 2'b00,
      PRIV_SUPER = 2'b01,
      PRIV_RSVD  = 2'b10,
      PRIV_MACH  = 2'b11
   } priv_e;

   localparam logic [6:0]  OPC_SYSTEM   = 7'b1110011;
   localparam logic [1:0]  RO_FIELD     = 2'b11;
   localparam int          ADDR_W       = 12;

   // decoded view of one control-register instruction
   typedef struct packed {
      logic              is_csr;
      logic              is_write;
      logic [ADDR_W-1:0] addr;
   } csr_req_t;

   // an inclusive span of defined addresses; super_ok marks spans reachable from Supervisor
   typedef struct packed {
      logic [ADDR_W-1:0] lo;
      logic [ADDR_W-1:0] hi;
      logic              super_ok;
   } csr_span_t;

   localparam int NUM_SPANS = 7;

   localparam csr_span_t [NUM_SPANS-1:0] SPANS = '{
      '{lo: 12'hF11, hi: 12'hF14, super_ok: 1'b0},
      '{lo: 12'h300, hi: 12'h306, super_ok: 1'b0},
      '{lo: 12'h340, hi: 12'h344, super_ok: 1'b0},
      '{lo: 12'h100, hi: 12'h100, super_ok: 1'b1},
      '{lo: 12'h102, hi: 12'h106, super_ok: 1'b1},
      '{lo: 12'h140, hi: 12'h144, super_ok: 1'b1},
      '{lo: 12'h180, hi: 12'h180, super_ok: 1'b1}
   };

endpackage

// File: rtl/csr_instr_decode.sv
module csr_instr_decode
   import csr_guard_pkg::*;
(
   input  logic [19:0] upper,    // instruction bits [31:12]
   input  logic [6:0]  opcode,   // instruction bits [6:0]
   output csr_req_t    req
);
   logic [2:0] funct3;
   logic [4:0] src;
   logic       variant_ok;
   logic       always_wr;

   assign funct3 = upper[2:0];
   assign src    = upper[7:3];

   always_comb begin
      variant_ok = 1'b0;
      always_wr  = 1'b0;
      unique case (funct3)
         3'b001, 3'b101: begin
            variant_ok = 1'b1;
            always_wr  = 1'b1;
         end
         3'b010, 3'b011, 3'b110, 3'b111: begin
            variant_ok = 1'b1;
            always_wr  = 1'b0;
         end
         default: begin
            variant_ok = 1'b0;
            always_wr  = 1'b0;
         end
      endcase
   end

   assign req.is_csr   = (opcode == OPC_SYSTEM) && variant_ok;
   assign req.is_write = always_wr || (src != 5'd0);
   assign req.addr     = upper[19:8];

endmodule

// File: rtl/csr_span_lookup.sv
module csr_span_lookup
   import csr_guard_pkg::*;
#(
   parameter int N_SPANS = NUM_SPANS
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic [1:0]        priv,
   output logic              defined
);
   logic [N_SPANS-1:0] hit;
   logic               is_mach;
   logic               is_super;

   assign is_mach  = (priv == PRIV_MACH);
   assign is_super = (priv == PRIV_SUPER);

   for (genvar i = 0; i < N_SPANS; i++) begin : g_span
      logic in_span;
      assign in_span = (addr >= SPANS[i].lo) && (addr <= SPANS[i].hi);
      if (SPANS[i].super_ok) begin : g_shared
         assign hit[i] = in_span && (is_mach || is_super);
      end else begin : g_mach_only
         assign hit[i] = in_span && is_mach;
      end
   end

   assign defined = |hit;

endmodule

// File: rtl/csr_rule_check.sv
module csr_rule_check
   import csr_guard_pkg::*;
#(
   parameter logic [ADDR_W-1:0] SATP_ADDR = 12'h180
) (
   input  csr_req_t   req,
   input  logic [1:0] priv,
   input  logic       tvm,
   input  logic       defined,
   output logic       permit
);
   logic ro_ok;
   logic level_ok;
   logic vm_ok;

   // read-only field in the upper address bits blocks any write
   assign ro_ok    = !(req.is_write && (req.addr[11:10] == RO_FIELD));
   // minimum privilege field, reserved encoding never passes
   assign level_ok = (priv >= req.addr[9:8]) && (priv != PRIV_RSVD);
   // translation register trapped from Supervisor under virtual-memory trapping
   assign vm_ok    = !((req.addr == SATP_ADDR) && (priv == PRIV_SUPER) && tvm);

   assign permit = defined && ro_ok && level_ok && vm_ok;

endmodule

// File: rtl/csr_access_guard.sv
module csr_access_guard
   import csr_guard_pkg::*;
#(
   parameter int          XLEN          = 32,
   parameter int          CAUSE_W       = 4,
   parameter int unsigned ILLEGAL_CAUSE = 2
) (
   input  logic               clk,
   input  logic               rst,
   input  logic               in_valid,
   input  logic [31:0]        instr,
   input  logic [1:0]         priv,
   input  logic               tvm,
   output logic               out_valid,
   output logic               legal,
   output logic               exc_valid,
   output logic [CAUSE_W-1:0] exc_cause,
   output logic [XLEN-1:0]    exc_tval
);
   localparam int ILEN     = 32;
   localparam int PAD_W    = (XLEN > ILEN) ? XLEN - ILEN : 1;
   localparam int CAUSE_MIN = $clog2(ILLEGAL_CAUSE + 1);

   if (XLEN < ILEN) begin : g_bad_xlen
      $error("XLEN must hold a full instruction word");
   end
   if (CAUSE_W < CAUSE_MIN || CAUSE_W < 1) begin : g_bad_cause
      $error("CAUSE_W too narrow for the cause code");
   end

   csr_req_t         req;
   logic             defined;
   logic             permit;
   logic             raise;
   logic [XLEN-1:0]  tval_ext;

   csr_instr_decode u_dec (
      .upper  (instr[31:12]),
      .opcode (instr[6:0]),
      .req    (req)
   );

   csr_span_lookup #(.N_SPANS(NUM_SPANS)) u_span (
      .addr    (req.addr),
      .priv    (priv),
      .defined (defined)
   );

   csr_rule_check #(.SATP_ADDR(12'h180)) u_rule (
      .req     (req),
      .priv    (priv),
      .tvm     (tvm),
      .defined (defined),
      .permit  (permit)
   );

   assign raise = req.is_csr && !permit;

   if (XLEN > ILEN) begin : g_wide
      logic [PAD_W-1:0] pad;
      assign pad      = '0;
      assign tval_ext = {pad, instr};
   end else begin : g_narrow
      assign tval_ext = instr;
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         out_valid <= 1'b0;
         legal     <= 1'b0;
         exc_valid <= 1'b0;
         exc_cause <= '0;
         exc_tval  <= '0;
      end else begin
         out_valid <= in_valid;
         legal     <= in_valid && !raise;
         exc_valid <= in_valid && raise;
         exc_cause <= (in_valid && raise) ? CAUSE_W'(ILLEGAL_CAUSE) : '0;
         exc_tval  <= (in_valid && raise) ? tval_ext : '0;
      end
   end

endmodule

// File: rtl/csr_access_guard_chk.sv
module csr_access_guard_chk #(
   parameter int          XLEN          = 32,
   parameter int          CAUSE_W       = 4,
   parameter int unsigned ILLEGAL_CAUSE = 2
) (
   input logic               clk,
   input logic               rst,
   input logic               in_valid,
   input logic [31:0]        instr,
   input logic [1:0]         priv,
   input logic               tvm,
   input logic               out_valid,
   input logic               legal,
   input logic               exc_valid,
   input logic [CAUSE_W-1:0] exc_cause,
   input logic [XLEN-1:0]    exc_tval
);
   logic sys_csr;
   assign sys_csr = (instr[6:0] == 7'b1110011) && (instr[13:12] != 2'b00);

   assert_valid_follows_R1: assert property (@(posedge clk) disable iff (rst)
      in_valid |=> out_valid);
   assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (rst)
      !in_valid |=> !out_valid);
   assert_foreign_no_trap_R2: assert property (@(posedge clk) disable iff (rst)
      (in_valid && instr[6:0] != 7'b1110011) |=> (legal && !exc_valid));
   assert_satp_trap_R8: assert property (@(posedge clk) disable iff (rst)
      (in_valid && sys_csr && instr[31:20] == 12'h180 && priv == 2'b01 && tvm) |=> exc_valid);
   assert_reserved_priv_R9: assert property (@(posedge clk) disable iff (rst)
      (in_valid && sys_csr && priv == 2'b10) |=> exc_valid);
   assert_trap_shape_R10: assert property (@(posedge clk) disable iff (rst)
      exc_valid |-> (out_valid && !legal && exc_cause == CAUSE_W'(ILLEGAL_CAUSE)));
   assert_trap_value_R10: assert property (@(posedge clk) disable iff (rst)
      exc_valid |-> (exc_tval[31:0] == $past(instr) && (exc_tval >> 32) == '0));
   assert_quiet_fields_R10: assert property (@(posedge clk) disable iff (rst)
      !exc_valid |-> (exc_cause == '0 && exc_tval == '0));
   assert_reset_clears_R11: assert property (@(posedge clk) disable iff (rst)
      $past(rst) |-> (!out_valid && !legal && !exc_valid));

endmodule

bind csr_access_guard csr_access_guard_chk #(
   .XLEN(XLEN), .CAUSE_W(CAUSE_W), .ILLEGAL_CAUSE(ILLEGAL_CAUSE)
) u_chk (.*);

// File: tb/sim_csr_access_guard.sv
module sim_csr_access_guard;
   localparam int PERIOD = 10;
   localparam int XLEN   = 32;
   localparam int CW     = 4;

   typedef struct {
      logic            ov;
      logic            lg;
      logic            ex;
      logic [CW-1:0]   cause;
      logic [XLEN-1:0] tval;
      string           tag;
   } exp_t;

   logic            clk = 1'b0;
   logic            rst = 1'b1;
   logic            in_valid = 1'b0;
   logic [31:0]     instr = '0;
   logic [1:0]      priv = 2'b11;
   logic            tvm = 1'b0;
   logic            out_valid, legal, exc_valid;
   logic [CW-1:0]   exc_cause;
   logic [XLEN-1:0] exc_tval;

   int checks = 0;
   int fails  = 0;
   bit done   = 0;
   exp_t sb[$];

   always #(PERIOD/2) clk = ~clk;

   csr_access_guard #(.XLEN(XLEN), .CAUSE_W(CW), .ILLEGAL_CAUSE(2)) u0 (
      .clk(clk), .rst(rst), .in_valid(in_valid), .instr(instr), .priv(priv),
      .tvm(tvm), .out_valid(out_valid), .legal(legal), .exc_valid(exc_valid),
      .exc_cause(exc_cause), .exc_tval(exc_tval)
   );

   function automatic logic [31:0] csr_op(logic [11:0] a, logic [4:0] src, logic [2:0] f3);
      return {a, src, f3, 5'd7, 7'b1110011};
   endfunction

   // expectation model written from the requirements
   function automatic exp_t model(logic [31:0] w, logic [1:0] p, logic t, logic r, string tag);
      exp_t e;
      logic [11:0] a;
      logic [2:0]  f3;
      logic csr, wr, m, s, def_m, def_s, good;
      e.tag = tag;
      e.ov = 1'b0; e.lg = 1'b0; e.ex = 1'b0; e.cause = '0; e.tval = '0;
      if (r) return e;
      e.ov = 1'b1;
      a  = w[31:20];
      f3 = w[14:12];
      csr = (w[6:0] == 7'b1110011) && f3 != 3'd0 && f3 != 3'd4;
      if (!csr) begin e.lg = 1'b1; return e; end
      wr = (f3 == 3'd1 || f3 == 3'd5) ? 1'b1 : (w[19:15] != 5'd0);
      m  = (p == 2'b11);
      s  = (p == 2'b01);
      def_m = (a >= 12'hF11 && a <= 12'hF14) || (a >= 12'h300 && a <= 12'h306) ||
              (a >= 12'h340 && a <= 12'h344);
      def_s = (a == 12'h100) || (a >= 12'h102 && a <= 12'h106) ||
              (a >= 12'h140 && a <= 12'h144) || (a == 12'h180);
      good = ((def_m && m) || (def_s && (m || s))) && !(wr && a[11:10] == 2'b11) &&
             (p >= a[9:8]) && (p != 2'b10) && !(a == 12'h180 && s && t);
      if (good) e.lg = 1'b1;
      else begin
         e.ex = 1'b1; e.cause = CW'(2); e.tval = XLEN'(w);
      end
      return e;
   endfunction

   task automatic send(logic [31:0] w, logic [1:0] p, logic t, logic r, string tag);
      @(negedge clk);
      rst = r; in_valid = 1'b1; instr = w; priv = p; tvm = t;
      sb.push_back(model(w, p, t, r, tag));
   endtask

   task automatic idle(int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         rst = 1'b0; in_valid = 1'b0; instr = 32'hDEAD_BEEF;
      end
   endtask

   // monitor: compare a quarter period after each rising edge
   initial begin
      exp_t e;
      forever begin
         @(posedge clk);
         #(PERIOD/4);
         if (sb.size() > 0) begin
            e = sb.pop_front();
            checks++;
            if (out_valid !== e.ov || legal !== e.lg || exc_valid !== e.ex ||
                exc_cause !== e.cause || exc_tval !== e.tval) begin
               fails++;
               $display("FAIL %s: got v=%b l=%b x=%b c=%0d t=%h exp v=%b l=%b x=%b c=%0d t=%h",
                        e.tag, out_valid, legal, exc_valid, exc_cause, exc_tval,
                        e.ov, e.lg, e.ex, e.cause, e.tval);
            end
         end else if (!rst && out_valid === 1'b1) begin
            checks++; fails++;
            $display("FAIL R1: got out_valid=1 exp out_valid=0 (no instruction presented)");
         end
      end
   end

   initial begin
      #(PERIOD * 50000);
      if (!done) begin
         checks++; fails++;
         $display("FAIL watchdog: got hang exp completion");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   initial begin
      // R11: reset state with a trapping instruction presented during reset
      send(csr_op(12'h999, 5'd0, 3'b010), 2'b11, 1'b0, 1'b1, "R11 reset");
      send(csr_op(12'h300, 5'd1, 3'b001), 2'b00, 1'b0, 1'b1, "R11 reset");
      idle(2);
      // R2: foreign instructions and the SYSTEM funct3 values that are not control-register ops
      send(32'h0050_0093, 2'b00, 1'b0, 1'b0, "R2 addi");
      send(32'h0000_0073, 2'b00, 1'b0, 1'b0, "R2 system f3=000");
      send({12'h999, 5'd3, 3'b100, 5'd1, 7'b1110011}, 2'b00, 1'b0, 1'b0, "R2 system f3=100");
      idle(1); // R1: idle gap must give out_valid low
      // R6: machine-only spans
      send(csr_op(12'h300, 5'd0, 3'b010), 2'b11, 1'b0, 1'b0, "R6 mach in M");
      send(csr_op(12'h300, 5'd0, 3'b010), 2'b01, 1'b0, 1'b0, "R6 mach in S");
      send(csr_op(12'h344, 5'd4, 3'b001), 2'b11, 1'b0, 1'b0, "R6 span top");
      send(csr_op(12'h307, 5'd0, 3'b010), 2'b11, 1'b0, 1'b0, "R7 gap 0x307");
      send(csr_op(12'h345, 5'd0, 3'b010), 2'b11, 1'b0, 1'b0, "R7 gap 0x345");
      send(csr_op(12'hF10, 5'd0, 3'b010), 2'b11, 1'b0, 1'b0, "R7 gap 0xF10");
      // R3 / R4: write determination against read-only addresses
      send(csr_op(12'hF11, 5'd0, 3'b001), 2'b11, 1'b0, 1'b0, "R3 R4 swap rs1=0 writes");
      send(csr_op(12'hF11, 5'd0, 3'b010), 2'b11, 1'b0, 1'b0, "R3 R4 set rs1=0 reads");
      send(csr_op(12'hF12, 5'd5, 3'b010), 2'b11, 1'b0, 1'b0, "R3 R4 set rs1=5 writes");
      send(csr_op(12'hF12, 5'd0, 3'b110), 2'b11, 1'b0, 1'b0, "R3 R4 seti uimm=0 reads");
      send(csr_op(12'hF13, 5'd0, 3'b101), 2'b11, 1'b0, 1'b0, "R3 R4 swapi uimm=0 writes");
      send(csr_op(12'hF14, 5'd0, 3'b011), 2'b11, 1'b0, 1'b0, "R3 R4 clr rs1=0 reads");
      send(csr_op(12'hF14, 5'd3, 3'b111), 2'b11, 1'b0, 1'b0, "R3 R4 clri uimm=3 writes");
      idle(2);
      // R7: spans shared by Supervisor and Machine
      send(csr_op(12'h100, 5'd2, 3'b001), 2'b01, 1'b0, 1'b0, "R7 0x100 in S");
      send(csr_op(12'h101, 5'd0, 3'b010), 2'b01, 1'b0, 1'b0, "R7 0x101 undefined");
      send(csr_op(12'h144, 5'd1, 3'b011), 2'b01, 1'b0, 1'b0, "R7 0x144 in S");
      send(csr_op(12'h106, 5'd0, 3'b010), 2'b11, 1'b0, 1'b0, "R7 0x106 in M");
      // R5: User below the Supervisor field
      send(csr_op(12'h100, 5'd0, 3'b010), 2'b00, 1'b0, 1'b0, "R5 User on 0x100");
      send(csr_op(12'h140, 5'd0, 3'b110), 2'b00, 1'b0, 1'b0, "R5 User on 0x140");
      // R8: translation register trap
      send(csr_op(12'h180, 5'd0, 3'b010), 2'b01, 1'b1, 1'b0, "R8 S tvm=1");
      send(csr_op(12'h180, 5'd0, 3'b010), 2'b01, 1'b0, 1'b0, "R8 S tvm=0");
      send(csr_op(12'h180, 5'd6, 3'b001), 2'b11, 1'b1, 1'b0, "R8 M tvm=1");
      send(csr_op(12'h100, 5'd0, 3'b010), 2'b01, 1'b1, 1'b0, "R8 other addr tvm=1");
      // R9: reserved privilege encoding
      send(csr_op(12'h300, 5'd0, 3'b010), 2'b10, 1'b0, 1'b0, "R9 rsvd on 0x300");
      send(csr_op(12'h100, 5'd0, 3'b010), 2'b10, 1'b0, 1'b0, "R9 rsvd on 0x100");
      send(32'h0050_0093, 2'b10, 1'b0, 1'b0, "R9 R2 rsvd foreign op");
      // R10: trap value carries the whole word, high fields set
      send({12'hFFF, 5'h1F, 3'b111, 5'h1F, 7'b1110011}, 2'b11, 1'b0, 1'b0, "R10 all-ones word");
      // R11: reset in the middle of traffic
      send(csr_op(12'h999, 5'd0, 3'b010), 2'b11, 1'b0, 1'b1, "R11 mid reset");
      send(csr_op(12'h341, 5'd9, 3'b011), 2'b11, 1'b0, 1'b0, "R6 R1 after reset");
      idle(3);
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

endmodule